// File: doc/BRIEF.md
# Blanking-Line Noise Classifier

The block estimates the luma noise of an incoming video signal by examining one chosen line during the vertical blanking period, when the picture carries no content and any sample-to-sample variation is noise. It counts lines from the vertical sync input. On the selected line it adds up the absolute differences between neighbouring luma samples. It then scales the sum down to a 5-bit metric and places the signal in one of three quality classes. The class is meant to drive a later stage that picks filter strength. That stage is not part of this block.

The measured line is chosen with a 3-bit code whose mapping to line numbers is deliberately non-monotonic. Code 000 selects line 4. That is the intended default because it avoids lines that carry text and data services. Two 5-bit thresholds set the class boundaries, and the suggested power-up values are 4 for the lower one and 16 for the upper one. A hold input freezes the automatic class, which is useful for tape sources whose blanking noise is misleading. A test override forces a class directly. A one-cycle valid strobe marks each completed measurement, once per field.

Top module: `nlc_top`

## Requirements
- R1: The line code selects the measured line as 000→4, 001→0, 010→1, 011→2, 100→3, 101→5, 110→7, 111→6.
- R2: The first rising `vsync` sample resets the line index to 0. The index advances at every high-to-low transition of `blank_n` and saturates at its maximum. Before the first `vsync` no line is measured. The active samples of a line are the cycles with `blank_n` high.
- R3: The metric is the sum of |p[i]−p[i−1]| over consecutive active samples of the measured line, shifted right by SHIFT (default 4) and saturated at 31.
- R4: Class encoding: 0 = low noise, 1 = middle, 2 = high. The class is 2 if metric ≥ `thr_hi`, otherwise 1 if metric ≥ `thr_lo`, otherwise 0.
- R5: `cls_valid` is a single-cycle pulse issued once per field. It is registered two clock edges after the edge that samples the end of the measured line, and `cls` shows the new class in that same cycle.
- R6: While `vcr_hold` is 1, measurements do not change the automatic class, which keeps the result of the last measurement taken with `vcr_hold` at 0. `cls_valid` still pulses.
- R7: While `ovr_en` is 1, `cls` follows `ovr_cls` in the same cycle: 00→0, 01→1, 10→2, 11→2. Clearing `ovr_en` restores the automatic class.
- R8: After reset, `cls` is 1 (middle) and `cls_valid` is 0.
- R9: `cls` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_y | input | DW | Luma sample |
| blank_n | input | 1 | Line blanking, low during blanking |
| vsync | input | 1 | Vertical sync, a rising edge starts a field |
| line_code | input | 3 | Measured-line select code |
| thr_lo | input | 5 | Low/middle boundary |
| thr_hi | input | 5 | Middle/high boundary |
| vcr_hold | input | 1 | Freeze automatic class |
| ovr_en | input | 1 | Enable class override |
| ovr_cls | input | 2 | Override class |
| cls | output | 2 | Noise class |
| cls_valid | output | 1 | One-cycle strobe per measurement |

## Verification
Every line code is run with several field patterns in which each line carries an alternating luma pattern of a different amplitude. A measurement taken on the wrong line therefore gives a different metric, and so a different class. For each field, the thresholds are set both to the fixed suggested pair and to values placed exactly at and next to the expected metric. This separates an off-by-one comparison or a scaling error from a correct result. Saturated metrics are covered by amplitudes that exceed the 5-bit range. Separate field sequences switch the hold and override inputs on and off to show that the held class survives changing noise and that the override takes effect at once and then releases.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

    localparam int MET_W   = 5;
    localparam int MET_MAX = (1 << MET_W) - 1;
    localparam int THR_LO_DEF = 4;
    localparam int THR_HI_DEF = 16;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'd0,
        CLS_MID  = 2'd1,
        CLS_HIGH = 2'd2
    } nlc_class_e;

    typedef struct packed {
        logic             done;
        logic [MET_W-1:0] metric;
    } nlc_meas_t;

    // Scrambled code-to-line mapping (R1)
    function automatic logic [2:0] nlc_decode_line(input logic [2:0] code);
        logic [2:0] ln;
        case (code)
            3'b000:  ln = 3'd4;
            3'b001:  ln = 3'd0;
            3'b010:  ln = 3'd1;
            3'b011:  ln = 3'd2;
            3'b100:  ln = 3'd3;
            3'b101:  ln = 3'd5;
            3'b110:  ln = 3'd7;
            default: ln = 3'd6;
        endcase
        return ln;
    endfunction

    function automatic nlc_class_e nlc_classify(input logic [MET_W-1:0] m,
                                                input logic [MET_W-1:0] lo,
                                                input logic [MET_W-1:0] hi);
        nlc_class_e c;
        if (m >= hi)      c = CLS_HIGH;
        else if (m >= lo) c = CLS_MID;
        else              c = CLS_LOW;
        return c;
    endfunction

    function automatic nlc_class_e nlc_ovr_map(input logic [1:0] code);
        nlc_class_e c;
        case (code)
            2'd0:    c = CLS_LOW;
            2'd1:    c = CLS_MID;
            default: c = CLS_HIGH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nlc_line_tracker.sv
module nlc_line_tracker #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blank_n,
    input  logic          vsync,
    output logic [LW-1:0] line_idx,
    output logic          line_end,
    output logic          field_start
);
    localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};

    logic blank_q;
    logic vs_q;

    assign line_end    = blank_q & ~blank_n;
    assign field_start = vsync & ~vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q  <= 1'b0;
            vs_q     <= 1'b0;
            line_idx <= LINE_MAX;
        end else begin
            blank_q <= blank_n;
            vs_q    <= vsync;
            if (field_start)
                line_idx <= '0;
            else if (line_end && line_idx != LINE_MAX)
                line_idx <= line_idx + 1'b1;
        end
    end

endmodule

// File: rtl/nlc_noise_acc.sv
module nlc_noise_acc
    import nlc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = 20,
    parameter int SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          sample_en,
    input  logic          close,
    input  logic [DW-1:0] pix,
    output nlc_meas_t     meas
);
    localparam logic [ACC_W-1:0] MET_LIM = ACC_W'(MET_MAX);

    logic [DW-1:0]    prev;
    logic             have_prev;
    logic [ACC_W-1:0] acc;
    logic [DW-1:0]    diff;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_next;
    logic [ACC_W-1:0] scaled;

    assign diff     = (pix >= prev) ? (pix - prev) : (prev - pix);
    assign sum      = {1'b0, acc} + (ACC_W + 1)'(diff);
    assign acc_next = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    assign scaled   = acc >> SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            have_prev <= 1'b0;
            acc       <= '0;
            meas      <= '0;
        end else begin
            meas.done <= 1'b0;
            if (restart) begin
                acc       <= '0;
                have_prev <= 1'b0;
            end else if (close) begin
                meas.done   <= 1'b1;
                meas.metric <= (scaled > MET_LIM) ? MET_W'(MET_MAX) : scaled[MET_W-1:0];
                acc         <= '0;
                have_prev   <= 1'b0;
            end else if (sample_en) begin
                if (have_prev)
                    acc <= acc_next;
                prev      <= pix;
                have_prev <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nlc_class_sel.sv
module nlc_class_sel
    import nlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  nlc_meas_t        meas,
    input  logic [MET_W-1:0] thr_lo,
    input  logic [MET_W-1:0] thr_hi,
    input  logic             vcr_hold,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_cls,
    output nlc_class_e       cls,
    output logic             cls_valid
);
    nlc_class_e auto_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q    <= CLS_MID;
            cls_valid <= 1'b0;
        end else begin
            cls_valid <= meas.done;
            if (meas.done && !vcr_hold)
                auto_q <= nlc_classify(meas.metric, thr_lo, thr_hi);
        end
    end

    assign cls = ovr_en ? nlc_ovr_map(ovr_cls) : auto_q;

endmodule

// File: rtl/nlc_top.sv
module nlc_top
    import nlc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LW    = 10,
    parameter int ACC_W = 20,
    parameter int SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pix_y,
    input  logic          blank_n,
    input  logic          vsync,
    input  logic [2:0]    line_code,
    input  logic [4:0]    thr_lo,
    input  logic [4:0]    thr_hi,
    input  logic          vcr_hold,
    input  logic          ovr_en,
    input  logic [1:0]    ovr_cls,
    output logic [1:0]    cls,
    output logic          cls_valid
);
    logic [LW-1:0] line_idx;
    logic          line_end;
    logic          field_start;
    logic [LW-1:0] target;
    logic          on_line;
    nlc_meas_t     meas;
    nlc_class_e    cls_e;

    nlc_line_tracker #(.LW(LW)) trk_i (
        .clk(clk), .rst(rst), .blank_n(blank_n), .vsync(vsync),
        .line_idx(line_idx), .line_end(line_end), .field_start(field_start)
    );

    assign target  = LW'(nlc_decode_line(line_code));
    assign on_line = (line_idx == target);

    nlc_noise_acc #(.DW(DW), .ACC_W(ACC_W), .SHIFT(SHIFT)) acc_i (
        .clk(clk), .rst(rst), .restart(field_start),
        .sample_en(blank_n && on_line), .close(line_end && on_line),
        .pix(pix_y), .meas(meas)
    );

    nlc_class_sel sel_i (
        .clk(clk), .rst(rst), .meas(meas), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .vcr_hold(vcr_hold), .ovr_en(ovr_en), .ovr_cls(ovr_cls),
        .cls(cls_e), .cls_valid(cls_valid)
    );

    assign cls = cls_e;

endmodule

// File: rtl/nlc_top_chk.sv
module nlc_top_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cls,
    input logic       cls_valid,
    input logic       vcr_hold,
    input logic       ovr_en,
    input logic [1:0] ovr_cls
);
    // R9
    cls_range_chk: assert property (@(posedge clk) disable iff (rst)
        cls != 2'd3);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cls_valid |=> !cls_valid);

    // R7
    ovr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && ovr_cls == 2'd0) |-> cls == 2'd0);

    // R7
    ovr_top_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && ovr_cls == 2'd3) |-> cls == 2'd2);

    // R6
    vcr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vcr_hold && $past(vcr_hold) && !ovr_en && !$past(ovr_en) && !$past(rst))
        |-> cls == $past(cls));

endmodule

bind nlc_top nlc_top_chk chk_i (
    .clk(clk), .rst(rst), .cls(cls), .cls_valid(cls_valid),
    .vcr_hold(vcr_hold), .ovr_en(ovr_en), .ovr_cls(ovr_cls)
);

// File: tb/nlc_top_tb_top.sv
module nlc_top_tb_top;

    localparam int NPIX   = 16;
    localparam int NLINES = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_y = '0;
    logic       blank_n = 1'b0;
    logic       vsync = 1'b0;
    logic [2:0] line_code = '0;
    logic [4:0] thr_lo = 5'd4;
    logic [4:0] thr_hi = 5'd16;
    logic       vcr_hold = 1'b0;
    logic       ovr_en = 1'b0;
    logic [1:0] ovr_cls = '0;
    logic [1:0] cls;
    logic       cls_valid;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int vcount = 0;
    int vcyc = 0;
    logic [1:0] vcls = '0;
    int hold_cls = 1;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cls_valid) begin
            vcount = vcount + 1;
            vcyc   = cyc;
            vcls   = cls;
        end
    end

    nlc_top dut_i (
        .clk(clk), .rst(rst), .pix_y(pix_y), .blank_n(blank_n), .vsync(vsync),
        .line_code(line_code), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .vcr_hold(vcr_hold), .ovr_en(ovr_en), .ovr_cls(ovr_cls),
        .cls(cls), .cls_valid(cls_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dec_line(input int code);
        case (code)
            0: return 4; 1: return 0; 2: return 1; 3: return 2;
            4: return 3; 5: return 5; 6: return 7; default: return 6;
        endcase
    endfunction

    function automatic int amp_of(input int ln, input int salt);
        return ((ln * 9 + salt * 13) % 40) + 1;
    endfunction

    function automatic int metric_of(input int amp);
        int m = ((NPIX - 1) * amp) >> 4;
        return (m > 31) ? 31 : m;
    endfunction

    function automatic int class_of(input int m, input int lo, input int hi);
        if (m >= hi) return 2;
        if (m >= lo) return 1;
        return 0;
    endfunction

    // One field: vsync, then NLINES lines of NPIX alternating samples
    task automatic run_field(input int code, input int salt, input int lo,
                             input int hi, input bit vcr);
        int end_cyc = 0;
        int tl = dec_line(code);
        int m  = metric_of(amp_of(tl, salt));
        int ec;
        @(negedge clk);
        line_code = 3'(code); thr_lo = 5'(lo); thr_hi = 5'(hi); vcr_hold = vcr;
        vcount = 0;
        blank_n = 1'b0; vsync = 1'b1;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        repeat (2) @(negedge clk);
        for (int ln = 0; ln < NLINES; ln++) begin
            for (int i = 0; i < NPIX; i++) begin
                blank_n = 1'b1;
                pix_y = (i % 2 == 1) ? 8'(amp_of(ln, salt) + 50) : 8'd50;
                @(negedge clk);
            end
            blank_n = 1'b0;
            if (ln == tl) end_cyc = cyc;
            repeat (4) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        ec = class_of(m, lo, hi);
        if (!vcr) hold_cls = ec;
        check("R5 pulses per field", vcount, 1);
        check("R5 valid latency", vcyc, end_cyc + 2);
        if (vcr)
            check("R6 held class", int'(vcls), hold_cls);
        else
            check("R1 R2 R3 R4 class", int'(vcls), ec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8 reset state
        check("R8 cls after reset", int'(cls), 1);
        check("R8 valid after reset", int'(cls_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 no strobe before vsync", vcount, 0);

        // Sweep codes, patterns and thresholds around the metric
        for (int code = 0; code < 8; code++) begin
            for (int salt = 0; salt < 4; salt++) begin
                int m = metric_of(amp_of(dec_line(code), salt));
                run_field(code, salt, 4, 16, 1'b0);
                run_field(code, salt, m, m, 1'b0);
                run_field(code, salt, 0, (m < 31) ? m + 1 : 31, 1'b0);
                if (m > 0) run_field(code, salt, m, 31, 1'b0);
            end
        end

        // R6: hold, then noise changes, class must not move
        run_field(0, 1, 4, 16, 1'b0);
        for (int salt = 0; salt < 4; salt++)
            run_field(salt + 1, salt, 0, 1, 1'b1);
        @(negedge clk);
        check("R6 class visible after hold", int'(cls), hold_cls);

        // R7: override mapping, immediate, and release
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ovr_en = 1'b1; ovr_cls = 2'(k);
            #1;
            check("R7 override", int'(cls), (k == 3) ? 2 : k);
            check("R9 no class 3", int'(cls == 2'd3), 0);
        end
        @(negedge clk);
        ovr_en = 1'b0;
        #1;
        check("R7 override release", int'(cls), hold_cls);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule